// File: doc/BRIEF.md
# Double-Sampled Shift Register with Sectioned Upset Detection

This block is a serial shift register in which every storage bit is sampled twice. A main flop on each bit captures its input on the rising edge of `clk_i` and forms the functional shift path. A shadow flop on the same bit captures the same input on the rising edge of `clk_dly_i`, which is supplied from outside. `clk_dly_i` lags `clk_i` so that its edge falls after the bit's input has settled and before the next main edge. Each bit compares the value its main flop takes with the value its shadow flop holds and registers the result. A transient or upset that moves the data between the shadow edge and the main edge therefore leaves a one-cycle flag on that bit.

The bits are grouped into contiguous sections. The flags of one section are reduced through an OR tree into a sticky section error. That error stays set until the error-clear input is asserted. Functionally the block can stand in for a plain shift register: the serial output and the parallel view come from the main flops only.

Top module: `dsr_shift_reg`

## Requirements
- R1: On every rising `clk_i` edge, bit 0 of `par_o` takes `ser_i` and bit i takes the previous value of bit i-1. `ser_o` always equals bit WIDTH-1 of `par_o`.
- R2: The shadow flop of each bit samples only on the rising edge of `clk_dly_i`. If one delayed edge is missing, the shadow values stay stale, and every bit whose input changed during that cycle flags a mismatch at the next main edge.
- R3: If the input of a bit changes after the delayed edge and before the main edge, the bit's flag is set at that main edge. The section error is visible on `sec_err_o` after the following main edge.
- R4: A bit whose main capture equals its shadow sample raises no flag. Shifting any data pattern with no timing fault never sets any bit of `sec_err_o`.
- R5: Bit s of `sec_err_o` is the OR of the flags of bits s*SEC_BITS to s*SEC_BITS+SEC_BITS-1 only. A fault in one section leaves the errors of all other sections at 0, even while the corrupted value shifts through them.
- R6: Once set, a section error stays at 1 until a main edge samples `err_clr_i` high.
- R7: A main edge that samples `err_clr_i` high clears every section error that has no flagged bit in that cycle.
- R8: If a bit flag is present in the same cycle as a clear, its section error stays at 1, so no detection is lost.
- R9: `rst_ni` low asynchronously clears the main flops, the shadow flops, the bit flags and the section errors. WIDTH (default 32) is a whole multiple of SEC_BITS (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock, drives the shift path, the flags and the section errors |
| clk_dly_i | input | 1 | Delayed copy of the main clock for the shadow flops |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Serial data input |
| err_clr_i | input | 1 | Clears the sticky section errors at a main edge |
| ser_o | output | 1 | Serial data output (last main flop) |
| par_o | output | WIDTH | Parallel view of all main flops, bit 0 nearest the input |
| sec_err_o | output | WIDTH/SEC_BITS | Sticky error per section |

## Verification
Several properties hold on every main edge: the one-step shift from the serial input through the parallel view, that a section error only rises after one of its own bits has flagged, its stickiness, its clearing, the precedence of a new flag over a clear, and the reset state. Whether a flag actually appears for a real timing fault can only be shown by the bench's scenarios. These scenarios are a data glitch placed between the delayed edge and the main edge, and a missing delayed pulse while a single one travels inside section 2. The same applies to the absence of false flags during long fault-free shifting, and to the confinement of an error to the section where the fault occurred.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
  localparam int unsigned DEF_WIDTH    = 32;
  localparam int unsigned DEF_SEC_BITS = 8;

  function automatic int unsigned sec_count(input int unsigned width, input int unsigned sec_bits);
    return width / sec_bits;
  endfunction

  function automatic int unsigned tree_pad(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/dsr_cell.sv
`timescale 1ns/1ps
module dsr_cell (
  input  logic clk_i,
  input  logic clk_dly_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic flag_o
);
  logic main_q, shadow_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) main_q <= 1'b0;
    else         main_q <= d_i;
  end

  always_ff @(posedge clk_dly_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= 1'b0;
    else         shadow_q <= d_i;
  end

  // shadow holds the delayed-edge sample taken before this main edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= d_i ^ shadow_q;
  end

  assign q_o    = main_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dsr_or_tree.sv
`timescale 1ns/1ps
module dsr_or_tree #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  localparam int unsigned P = dsr_pkg::tree_pad(N);

  logic [2*P-2:0] node;

  for (genvar l = 0; l < P; l++) begin : g_leaf
    if (l < N) begin : g_used
      assign node[P-1+l] = in_i[l];
    end else begin : g_pad
      assign node[P-1+l] = 1'b0;
    end
  end

  for (genvar k = 0; k + 1 < P; k++) begin : g_node
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign out_o = node[0];
endmodule

// File: rtl/dsr_section.sv
`timescale 1ns/1ps
module dsr_section #(
  parameter int unsigned SEC_BITS = 8
) (
  input  logic                clk_i,
  input  logic                clk_dly_i,
  input  logic                rst_ni,
  input  logic                err_clr_i,
  input  logic                d_i,
  output logic [SEC_BITS-1:0] q_o,
  output logic                err_o
);
  logic [SEC_BITS:0]   chain;
  logic [SEC_BITS-1:0] flags;
  logic                any_flag;
  logic                err_q;

  assign chain[0] = d_i;

  for (genvar b = 0; b < SEC_BITS; b++) begin : g_bit
    dsr_cell u_cell (
      .clk_i     (clk_i),
      .clk_dly_i (clk_dly_i),
      .rst_ni    (rst_ni),
      .d_i       (chain[b]),
      .q_o       (chain[b+1]),
      .flag_o    (flags[b])
    );
  end

  dsr_or_tree #(.N(SEC_BITS)) u_tree (
    .in_i  (flags),
    .out_o (any_flag)
  );

  // new flag outranks clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (err_clr_i ? 1'b0 : err_q) | any_flag;
  end

  assign q_o   = chain[SEC_BITS:1];
  assign err_o = err_q;

  p_set_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(|flags));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !(|flags)) |=> !err_q);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags) |=> err_q);
endmodule

// File: rtl/dsr_shift_reg.sv
`timescale 1ns/1ps
module dsr_shift_reg #(
  parameter int unsigned WIDTH    = dsr_pkg::DEF_WIDTH,
  parameter int unsigned SEC_BITS = dsr_pkg::DEF_SEC_BITS
) (
  input  logic                                         clk_i,
  input  logic                                         clk_dly_i,
  input  logic                                         rst_ni,
  input  logic                                         ser_i,
  input  logic                                         err_clr_i,
  output logic                                         ser_o,
  output logic [WIDTH-1:0]                             par_o,
  output logic [dsr_pkg::sec_count(WIDTH, SEC_BITS)-1:0] sec_err_o
);
  localparam int unsigned NUM_SEC = dsr_pkg::sec_count(WIDTH, SEC_BITS);

  logic [NUM_SEC-1:0] sec_in;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    if (s == 0) begin : g_head
      assign sec_in[s] = ser_i;
    end else begin : g_link
      assign sec_in[s] = par_o[s*SEC_BITS-1];
    end

    dsr_section #(.SEC_BITS(SEC_BITS)) u_sec (
      .clk_i     (clk_i),
      .clk_dly_i (clk_dly_i),
      .rst_ni    (rst_ni),
      .err_clr_i (err_clr_i),
      .d_i       (sec_in[s]),
      .q_o       (par_o[s*SEC_BITS +: SEC_BITS]),
      .err_o     (sec_err_o[s])
    );
  end

  assign ser_o = par_o[WIDTH-1];

  p_shift_head_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> par_o[0] == $past(ser_i));
  p_shift_body_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> par_o[WIDTH-1:1] == $past(par_o[WIDTH-2:0]));
  p_reset_state_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (par_o == '0 && sec_err_o == '0));
endmodule

// File: tb/dsr_shift_reg_tb_top.sv
`timescale 1ns/1ps
module dsr_shift_reg_tb_top;
  localparam int W  = 32;
  localparam int SB = 8;
  localparam int NS = W / SB;

  logic clk = 1'b0;
  logic clk_dly = 1'b0;
  logic dly_en = 1'b1;
  logic rst_ni = 1'b0;
  logic ser_i = 1'b0;
  logic err_clr_i = 1'b0;
  logic glitch_val = 1'b0;
  logic ser_o;
  logic [W-1:0] par_o;
  logic [NS-1:0] sec_err_o;

  int checks = 0;
  int fails = 0;

  typedef struct packed {
    logic [W-1:0]  par;
    logic          ser;
    logic [NS-1:0] sec;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  logic [W-1:0]  m_main = '0;
  logic [W-1:0]  m_sh   = '0;
  logic [W-1:0]  m_flag = '0;
  logic [NS-1:0] m_sec  = '0;

  dsr_shift_reg #(.WIDTH(W), .SEC_BITS(SB)) dut_i (
    .clk_i     (clk),
    .clk_dly_i (clk_dly),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .err_clr_i (err_clr_i),
    .ser_o     (ser_o),
    .par_o     (par_o),
    .sec_err_o (sec_err_o)
  );

  // 250 MHz main clock, rising at 4k+2
  initial forever #2 clk = ~clk;

  // delayed clock rises 3 ns after each main edge (4k+1)
  initial begin
    #1;
    forever begin
      clk_dly = dly_en;
      #2;
      clk_dly = 1'b0;
      #2;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_main = '0; m_sh = '0; m_flag = '0; m_sec = '0;
  endtask

  // one main cycle: glitch flips ser_i between delayed and main edge,
  // drop suppresses the delayed pulse of this cycle
  task automatic step(input logic v, input logic glitch, input logic drop,
                      input logic clr, input string req);
    logic [W-1:0] nm;
    logic         cap;
    @(negedge clk);
    ser_i = v;
    err_clr_i = clr;
    dly_en = !drop;
    glitch_val = ~v;
    if (glitch) begin
      fork
        begin #1.5; ser_i = glitch_val; end
      join_none
    end
    cap = glitch ? ~v : v;
    nm = {m_main[W-2:0], cap};
    if (!drop) m_sh = {m_main[W-2:0], v};
    if (clr) m_sec = '0;
    for (int s = 0; s < NS; s++) m_sec[s] = m_sec[s] | (|m_flag[s*SB +: SB]);
    m_flag = nm ^ m_sh;
    m_main = nm;
    exp_q.push_back('{par: m_main, ser: m_main[W-1], sec: m_sec});
    req_q.push_back(req);
  endtask

  // scoreboard monitor, samples 1 ns after each main edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({r, " par"}, par_o, e.par);
        chk({r, " ser"}, W'(ser_o), W'(e.ser));
        chk({r, " sec"}, W'(sec_err_o), W'(e.sec));
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    #7;
    chk("R9 reset par", par_o, '0);
    chk("R9 reset sec", W'(sec_err_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();

    // R1/R4: fault-free shifting of varied patterns
    for (int i = 0; i < 40; i++) step(1'($urandom_range(1)), 1'b0, 1'b0, 1'b0, "R1/R4");
    for (int i = 0; i < 36; i++) step(i[0], 1'b0, 1'b0, 1'b0, "R1/R4 alt");

    // R3/R5: glitch on input flags section 0 only while bad bit travels
    step(1'b1, 1'b1, 1'b0, 1'b0, "R3 glitch");
    for (int i = 0; i < 34; i++) step(i[1], 1'b0, 1'b0, 1'b0, "R5/R6 sticky");

    // R7: clear with no pending flag
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 clear");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7 after");

    // R8: flag in the same cycle as clear keeps the error
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 glitch");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R8 clear");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R8 held");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 clear2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 after2");

    // R9: asynchronous reset mid-run
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b0;
    #0.5;
    chk("R9 midrun par", par_o, '0);
    chk("R9 midrun sec", W'(sec_err_o), '0);
    model_reset();
    @(negedge clk);
    rst_ni = 1'b1;

    // R2/R5: single one moves 18->19 while delayed pulse is missing
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 load");
    for (int i = 0; i < 18; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R2 walk");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R2 drop");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R2/R5 section2");

    @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule